// File: doc/BRIEF.md
# CAN Bit Timing and Resynchronization Unit

This unit builds the time structure of a CAN bit from the system clock. A programmable prescaler divides the clock into time quanta. A segment sequencer then walks each bit through three states: a one-quantum sync segment, a first timing segment that covers propagation plus phase 1, and a second timing segment that equals phase 2. At the boundary between the two timing segments it fires a one-cycle sample strobe and latches the receive line.

Timing comes from one packed 16-bit configuration word plus a prescaler extension input. Every field in the word is stored as its value minus one. The sequencer watches the synchronized receive line for recessive-to-dominant edges.
- While the bus is idle and hard sync is enabled, such an edge restarts the bit.
- Otherwise the edge moves the sample point by an amount limited by the synchronization jump width (SJW): a late edge lengthens the first timing segment, and an early edge shortens the second.

A frame-level controller uses the strobe, the sampled bit and the bit-start pulse.

Top module: `can_bit_timer`

## Requirements
- R1: After reset, `seg` is 0 (sync segment), `sample_stb` and `bit_start` are low, and `sample_bit` is 1 (recessive).
- R2: The configuration word is decoded as follows:
  - bits 14:12 hold phase-2 length minus 1 (TS2);
  - bits 11:8 hold propagation plus phase-1 length minus 1 (TS1);
  - bits 7:6 hold SJW minus 1;
  - bits 5:0 hold the prescaler minus 1;
  - bit 15 is ignored.

  A bit with no resynchronization lasts 1 + (TS1+1) + (TS2+1) quanta, so the word 0x6FC0 gives 24 quanta.
- R3: One quantum lasts ({brp_ext, brp}+1) clock cycles. An extension value of zero adds nothing.
- R4: `seg` steps through 0 (sync), 1 (first timing segment) and 2 (second timing segment), in that order.
  - `sample_stb` pulses for one cycle as `seg` enters 2, and `sample_bit` takes the value `rx_sync` had at that sample point.
  - `bit_start` pulses for one cycle as `seg` enters 0.
- R5: A 1-to-0 edge on `rx_sync` while `hard_sync_en` and `bus_idle` are both high has these effects:
  - the quantum restarts;
  - on the next cycle `seg` is 1, at its first quantum;
  - no `bit_start` is issued;
  - no further resynchronization is applied in that bit.
- R6: An edge that arrives in the first timing segment lengthens it by min(lateness, SJW). The lateness is the number of quanta elapsed since the end of the sync segment, counting the current quantum.
- R7: An edge that arrives in the second timing segment shortens it by min(earliness, SJW). The earliness is the number of quanta left in the segment, counting the current one. The segment always completes its current quantum.
- R8: At most one edge per bit is acted on. Later edges in the same bit are ignored.
- R9: An edge that arrives while `tx_bit` is 0 (the node is transmitting dominant) causes no resynchronization.
- R10: An edge in the sync segment causes no correction, but it still counts as the one edge acted on for that bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_word | input | 16 | Packed bit timing word (TS2, TS1, SJW, prescaler; all stored minus 1) |
| cfg_brp_ext | input | BRPE_W | Prescaler extension, upper bits of the prescaler minus 1 |
| rx_sync | input | 1 | Synchronized receive line, 0 = dominant |
| tx_bit | input | 1 | Bit currently transmitted, 0 = dominant |
| hard_sync_en | input | 1 | Allows hard synchronization |
| bus_idle | input | 1 | Bus is idle |
| sample_stb | output | 1 | One-cycle strobe at the sample point |
| sample_bit | output | 1 | Receive value captured at the last sample point |
| bit_start | output | 1 | One-cycle pulse at the start of a bit |
| seg | output | 2 | Current segment: 0 sync, 1 first timing, 2 second timing |

## Verification
The bench first runs quiet bits under three configurations: a clock-rate quantum, a doubled prescaler, and a set extension field. Comparing these separates field decoding errors from prescaler errors.

Single edges are then placed at known quanta:
- one late in the first segment;
- one early in the second segment;
- one at the end of a short second segment;
- one in the sync segment;
- one while transmitting dominant;
- one while idle with hard sync on.

These separate lengthening, shortening, the floor on shortening, the sync-segment case, suppression, and restart, since each produces a different bit length. Pairs of edges in one bit expose any second correction. A long pseudo-random run of edges, transmit values and idle flags is compared cycle by cycle against the reference model.

// File: rtl/cbt_pkg.sv
package cbt_pkg;
   localparam int TS2_W   = 3;
   localparam int TS1_W   = 4;
   localparam int SJW_W   = 2;
   localparam int BRP_W   = 6;
   localparam int CFG_W   = 1 + TS2_W + TS1_W + SJW_W + BRP_W;
   localparam int SEG_CNT_W = TS1_W + 1;

   typedef enum logic [1:0] {
      SEG_SYNC = 2'd0,
      SEG_TS1  = 2'd1,
      SEG_TS2  = 2'd2
   } seg_e;

   typedef struct packed {
      logic             spare;
      logic [TS2_W-1:0] ts2_m1;
      logic [TS1_W-1:0] ts1_m1;
      logic [SJW_W-1:0] sjw_m1;
      logic [BRP_W-1:0] brp_m1;
   } bt_cfg_t;
endpackage

// File: rtl/cbt_prescaler.sv
module cbt_prescaler #(
   parameter int DIV_W = 10
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             restart,
   input  logic [DIV_W-1:0] div_m1,
   output logic             tick
);
   logic [DIV_W-1:0] pc;

   assign tick = (pc >= div_m1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                pc <= '0;
      else if (restart || tick)  pc <= '0;
      else                       pc <= pc + DIV_W'(1);
   end
endmodule

// File: rtl/cbt_seg_fsm.sv
module cbt_seg_fsm
   import cbt_pkg::*;
#(
   parameter int CNT_W = SEG_CNT_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             fall,
   input  logic             hard,
   input  logic             tx_dom,
   input  logic             rx,
   input  logic [TS1_W-1:0] ts1_m1,
   input  logic [TS2_W-1:0] ts2_m1,
   input  logic [SJW_W-1:0] sjw_m1,
   output seg_e             seg,
   output logic             sample_stb,
   output logic             sample_bit,
   output logic             bit_start
);
   localparam int ADJ_W = SJW_W + 1;
   localparam int L2_W  = TS2_W + 1;

   logic [CNT_W-1:0] cnt;
   logic [ADJ_W-1:0] sjw, ext1, sh2, ext1_n, sh2_n, lat_cl, early_cl;
   logic [CNT_W-1:0] lat;
   logic [L2_W-1:0]  l2, early;
   logic             done, done_n, resync_ok, ts1_last, ts2_last;

   assign sjw      = ADJ_W'(sjw_m1) + ADJ_W'(1);
   assign lat      = cnt + CNT_W'(1);
   assign lat_cl   = (lat > CNT_W'(sjw)) ? sjw : lat[ADJ_W-1:0];
   assign l2       = L2_W'(ts2_m1) + L2_W'(1);
   assign early    = l2 - cnt[L2_W-1:0];
   assign early_cl = (early > L2_W'(sjw)) ? sjw : early[ADJ_W-1:0];
   assign resync_ok = fall && !hard && !done && !tx_dom;

   always_comb begin
      ext1_n = ext1;
      sh2_n  = sh2;
      done_n = done;
      if (resync_ok) begin
         done_n = 1'b1;
         unique case (seg)
            SEG_TS1: ext1_n = lat_cl;
            SEG_TS2: sh2_n  = early_cl;
            default: ;
         endcase
      end
   end

   assign ts1_last = (cnt >= CNT_W'(ts1_m1) + CNT_W'(ext1_n));
   assign ts2_last = (cnt + CNT_W'(1) + CNT_W'(sh2_n) >= CNT_W'(l2));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         seg        <= SEG_SYNC;
         cnt        <= '0;
         ext1       <= '0;
         sh2        <= '0;
         done       <= 1'b0;
         sample_stb <= 1'b0;
         bit_start  <= 1'b0;
         sample_bit <= 1'b1;
      end else begin
         sample_stb <= 1'b0;
         bit_start  <= 1'b0;
         if (hard) begin
            seg  <= SEG_TS1;
            cnt  <= '0;
            ext1 <= '0;
            sh2  <= '0;
            done <= 1'b1;
         end else begin
            ext1 <= ext1_n;
            sh2  <= sh2_n;
            done <= done_n;
            if (tick) begin
               unique case (seg)
                  SEG_SYNC: begin
                     seg <= SEG_TS1;
                     cnt <= '0;
                  end
                  SEG_TS1: begin
                     if (ts1_last) begin
                        seg        <= SEG_TS2;
                        cnt        <= '0;
                        sample_stb <= 1'b1;
                        sample_bit <= rx;
                     end else begin
                        cnt <= cnt + CNT_W'(1);
                     end
                  end
                  SEG_TS2: begin
                     if (ts2_last) begin
                        seg       <= SEG_SYNC;
                        cnt       <= '0;
                        ext1      <= '0;
                        sh2       <= '0;
                        done      <= 1'b0;
                        bit_start <= 1'b1;
                     end else begin
                        cnt <= cnt + CNT_W'(1);
                     end
                  end
                  default: seg <= SEG_SYNC;
               endcase
            end
         end
      end
   end
endmodule

// File: rtl/can_bit_timer.sv
module can_bit_timer
   import cbt_pkg::*;
#(
   parameter int BRPE_W = 4,
   parameter int DIV_W  = BRP_W + BRPE_W
) (
   input  logic                                  clk,
   input  logic                                  rst_n,
   input  logic [CFG_W-1:0]                      cfg_word,
   input  logic [((BRPE_W > 0) ? BRPE_W : 1)-1:0] cfg_brp_ext,
   input  logic                                  rx_sync,
   input  logic                                  tx_bit,
   input  logic                                  hard_sync_en,
   input  logic                                  bus_idle,
   output logic                                  sample_stb,
   output logic                                  sample_bit,
   output logic                                  bit_start,
   output logic [1:0]                            seg
);
   bt_cfg_t          cfg;
   logic [DIV_W-1:0] div_m1;
   logic             rx_prev, fall_evt, hard_evt, q_tick;
   logic             unused_spare;
   seg_e             seg_q;

   assign cfg          = bt_cfg_t'(cfg_word);
   assign unused_spare = cfg.spare;

   if (BRPE_W > 0) begin : g_ext
      assign div_m1 = {cfg_brp_ext, cfg.brp_m1};
   end else begin : g_noext
      logic unused_ext;
      assign unused_ext = cfg_brp_ext[0];
      assign div_m1     = DIV_W'(cfg.brp_m1);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) rx_prev <= 1'b1;
      else        rx_prev <= rx_sync;
   end

   assign fall_evt = rx_prev && !rx_sync;
   assign hard_evt = fall_evt && hard_sync_en && bus_idle;

   cbt_prescaler #(.DIV_W(DIV_W)) u_presc (
      .clk     (clk),
      .rst_n   (rst_n),
      .restart (hard_evt),
      .div_m1  (div_m1),
      .tick    (q_tick)
   );

   cbt_seg_fsm u_fsm (
      .clk        (clk),
      .rst_n      (rst_n),
      .tick       (q_tick),
      .fall       (fall_evt),
      .hard       (hard_evt),
      .tx_dom     (!tx_bit),
      .rx         (rx_sync),
      .ts1_m1     (cfg.ts1_m1),
      .ts2_m1     (cfg.ts2_m1),
      .sjw_m1     (cfg.sjw_m1),
      .seg        (seg_q),
      .sample_stb (sample_stb),
      .sample_bit (sample_bit),
      .bit_start  (bit_start)
   );

   assign seg = seg_q;
endmodule

// File: rtl/cbt_checker.sv
module cbt_checker #(
   parameter int BRPE_W = 4
) (
   input logic       clk,
   input logic       rst_n,
   input logic [1:0] seg,
   input logic       sample_stb,
   input logic       bit_start,
   input logic       hard
);
   initial begin
      assert (BRPE_W >= 0 && BRPE_W <= 10)
         else $error("prescaler extension width out of range");
   end

   // R4: no encoding 3
   p_seg_legal_r4: assert property (@(posedge clk) disable iff (!rst_n)
      seg != 2'd3);

   // R4: strobe marks the move from the first to the second timing segment
   p_stb_boundary_r4: assert property (@(posedge clk) disable iff (!rst_n)
      sample_stb |-> (seg == 2'd2 && $past(seg) == 2'd1));

   // R4: bit start marks the move from the second segment into sync
   p_bs_sync_r4: assert property (@(posedge clk) disable iff (!rst_n)
      bit_start |-> (seg == 2'd0 && $past(seg) == 2'd2));

   // R4: strobe is a single-cycle pulse
   p_stb_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
      sample_stb |=> !sample_stb);

   // R4: the first timing segment is entered only from sync unless hard sync
   p_order_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (seg == 2'd1 && $past(seg) != 2'd1 && !$past(hard)) |-> $past(seg) == 2'd0);

   // R5: hard sync lands in the first timing segment without pulses
   p_hard_restart_r5: assert property (@(posedge clk) disable iff (!rst_n)
      hard |=> (seg == 2'd1 && !bit_start && !sample_stb));
endmodule

bind can_bit_timer cbt_checker #(.BRPE_W(BRPE_W)) u_cbt_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .seg        (seg),
   .sample_stb (sample_stb),
   .bit_start  (bit_start),
   .hard       (hard_evt)
);

// File: tb/tb_can_bit_timer.sv
module tb_can_bit_timer;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] cfg_word = 16'h6FC0;
   logic [3:0]  cfg_brp_ext = 4'd0;
   logic        rx_sync = 1'b1;
   logic        tx_bit = 1'b1;
   logic        hard_sync_en = 1'b0;
   logic        bus_idle = 1'b0;
   logic        sample_stb, sample_bit, bit_start;
   logic [1:0]  seg;

   int    n_chk = 0;
   int    n_fail = 0;
   string cur_req = "R4";
   bit    done_flag = 1'b0;

   always #10 clk = ~clk;

   can_bit_timer dut (
      .clk(clk), .rst_n(rst_n), .cfg_word(cfg_word), .cfg_brp_ext(cfg_brp_ext),
      .rx_sync(rx_sync), .tx_bit(tx_bit), .hard_sync_en(hard_sync_en),
      .bus_idle(bus_idle), .sample_stb(sample_stb), .sample_bit(sample_bit),
      .bit_start(bit_start), .seg(seg)
   );

   // behavioural reference: quantum index within the bit and clock within the quantum
   int m_clk, m_idx, m_ext, m_sh, m_done, m_prev;
   int e_seg, e_stb, e_bs, e_sbit;

   always @(posedge clk) begin
      int l1, l2, div, sjw, c;
      bit fall, tick;
      if (!rst_n) begin
         m_clk = 0; m_idx = 0; m_ext = 0; m_sh = 0; m_done = 0; m_prev = 1;
         e_seg = 0; e_stb = 0; e_bs = 0; e_sbit = 1;
      end else begin
         l1   = int'(cfg_word[11:8]) + 1;
         l2   = int'(cfg_word[14:12]) + 1;
         sjw  = int'(cfg_word[7:6]) + 1;
         div  = int'({cfg_brp_ext, cfg_word[5:0]}) + 1;
         fall = (m_prev == 1) && (rx_sync == 1'b0);
         tick = (m_clk >= div - 1);
         e_stb = 0; e_bs = 0;
         if (fall && hard_sync_en && bus_idle) begin
            m_idx = 1; m_clk = 0; m_done = 1; m_ext = 0; m_sh = 0;
         end else begin
            if (fall && m_done == 0 && tx_bit) begin
               m_done = 1;
               if (m_idx == 0) begin
               end else if (m_idx <= l1 + m_ext) begin
                  m_ext = (m_idx < sjw) ? m_idx : sjw;
               end else begin
                  c = m_idx - (l1 + m_ext) - 1;
                  m_sh = ((l2 - c) < sjw) ? (l2 - c) : sjw;
               end
            end
            if (tick) begin
               m_clk = 0;
               if (m_idx == 0) m_idx = 1;
               else if (m_idx < l1 + m_ext) m_idx++;
               else if (m_idx == l1 + m_ext) begin
                  m_idx++; e_stb = 1; e_sbit = rx_sync;
               end else begin
                  c = m_idx - (l1 + m_ext) - 1;
                  if (c + 1 + m_sh >= l2) begin
                     m_idx = 0; m_ext = 0; m_sh = 0; m_done = 0; e_bs = 1;
                  end else m_idx++;
               end
            end else m_clk++;
         end
         m_prev = rx_sync;
         e_seg = (m_idx == 0) ? 0 : (m_idx <= l1 + m_ext) ? 1 : 2;
      end
   end

   task automatic check(input string req, input string what, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   // cycle comparison against the model, away from the active edge
   always @(negedge clk) begin
      if (rst_n && !done_flag) begin
         n_chk++;
         if (int'(seg) != e_seg || int'(sample_stb) != e_stb ||
             int'(bit_start) != e_bs || int'(sample_bit) != e_sbit) begin
            n_fail++;
            $display("FAIL %s model: actual seg=%0d stb=%0d bs=%0d sb=%0d expected seg=%0d stb=%0d bs=%0d sb=%0d",
                     cur_req, seg, sample_stb, bit_start, sample_bit, e_seg, e_stb, e_bs, e_sbit);
         end
      end
   end

   task automatic do_reset(input logic [15:0] w, input logic [3:0] ext);
      @(negedge clk);
      rst_n = 1'b0; cfg_word = w; cfg_brp_ext = ext;
      rx_sync = 1'b1; tx_bit = 1'b1; hard_sync_en = 1'b0; bus_idle = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
   endtask

   // waits for a bit start, plays up to two dominant pulses at given quanta, returns the length
   task automatic run_bit(input int e1, input int e2, input int hold, output int len, output int stb_at);
      do @(negedge clk); while (!bit_start);
      len = 0; stb_at = -1;
      for (int i = 0; i < 5000; i++) begin
         if (i == e1 || i == e2) rx_sync = 1'b0;
         if ((e1 >= 0 && i == e1 + hold) || (e2 >= 0 && i == e2 + hold)) rx_sync = 1'b1;
         @(negedge clk);
         if (sample_stb) stb_at = i + 1;
         if (bit_start) begin len = i + 1; break; end
      end
      rx_sync = 1'b1;
   endtask

   logic [15:0] lfsr = 16'hACE1;
   function automatic logic [15:0] step_lfsr(input logic [15:0] v);
      return {v[14:0], v[15] ^ v[13] ^ v[12] ^ v[10]};
   endfunction

   initial begin
      int len, sa;
      // R1: reset state
      repeat (2) @(negedge clk);
      check("R1", "seg", int'(seg), 0);
      check("R1", "sample_stb", int'(sample_stb), 0);
      check("R1", "bit_start", int'(bit_start), 0);
      check("R1", "sample_bit", int'(sample_bit), 1);
      rst_n = 1'b1;

      // R2: 0x6FC0 gives 24 clocks per bit; R4 sample point 7 quanta before bit end
      cur_req = "R2";
      run_bit(-1, -1, 1, len, sa);
      check("R2", "bit length 0x6FC0", len, 24);
      cur_req = "R4";
      run_bit(-1, -1, 1, len, sa);
      check("R4", "strobe offset", sa, 17);

      // R2: spare bit 15 ignored
      do_reset(16'hEFC0, 4'd0);
      cur_req = "R2";
      run_bit(-1, -1, 1, len, sa);
      check("R2", "bit length with bit 15 set", len, 24);

      // R3: prescaler field and extension
      do_reset(16'h6FC1, 4'd0);
      cur_req = "R3";
      run_bit(-1, -1, 1, len, sa);
      check("R3", "bit length prescaler 2", len, 48);
      do_reset(16'h1100, 4'd1);
      run_bit(-1, -1, 1, len, sa);
      check("R3", "bit length extension 1", len, 325);

      do_reset(16'h6FC0, 4'd0);
      // R6: late edge at quantum 8 lengthens by SJW 4
      cur_req = "R6";
      run_bit(8, -1, 1, len, sa);
      check("R6", "lengthened bit", len, 28);
      // R7: early edge at quantum 18 shortens by 4
      cur_req = "R7";
      run_bit(18, -1, 1, len, sa);
      check("R7", "shortened bit", len, 20);
      // R8: second edge in the same bit ignored
      cur_req = "R8";
      run_bit(8, 22, 1, len, sa);
      check("R8", "two edges one correction", len, 28);
      // R10: edge in sync segment consumes the bit's correction
      cur_req = "R10";
      run_bit(0, 8, 1, len, sa);
      check("R10", "sync edge then late edge", len, 24);
      // R9: transmitting dominant blocks correction; R4 sample of dominant
      cur_req = "R9";
      tx_bit = 1'b0;
      run_bit(5, -1, 15, len, sa);
      check("R9", "no correction while tx dominant", len, 24);
      check("R4", "sampled dominant", int'(sample_bit), 0);
      tx_bit = 1'b1;
      // R5: hard sync at quantum 10 restarts the bit
      cur_req = "R5";
      hard_sync_en = 1'b1; bus_idle = 1'b1;
      run_bit(10, -1, 1, len, sa);
      check("R5", "bit length after hard sync", len, 34);
      hard_sync_en = 1'b0; bus_idle = 1'b0;

      // R7: phase 2 of 2 quanta, edge at its first quantum cannot go below zero
      do_reset(16'h1FC0, 4'd0);
      cur_req = "R7";
      run_bit(-1, -1, 1, len, sa);
      check("R7", "short phase 2 bit length", len, 19);
      run_bit(17, -1, 1, len, sa);
      check("R7", "clamped shortening", len, 18);

      // pseudo-random traffic compared against the model
      for (int k = 0; k < 2; k++) begin
         do_reset(k == 0 ? 16'h6FC0 : 16'h12C2, 4'd0);
         cur_req = "R7";
         for (int n = 0; n < 3000; n++) begin
            @(negedge clk);
            lfsr = step_lfsr(lfsr);
            if (lfsr[2:0] == 3'd0) rx_sync = ~rx_sync;
            tx_bit       = (lfsr[6:4] != 3'd0);
            bus_idle     = (lfsr[9:8] == 2'd0);
            hard_sync_en = lfsr[11];
         end
      end

      done_flag = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done_flag) begin
         done_flag = 1'b1;
         n_chk++;
         n_fail++;
         $display("FAIL %s watchdog: actual timeout expected completion", cur_req);
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end
endmodule